// File: doc/BRIEF.md
# Audio DAC Output Power Sequencer

This block steps an audio DAC output stage through power-up and power-down without audible pops. It watches the DAC reset pin, a power-down control bit, a configuration-mode select (pin-strap or register control), a speed select and an anti-pop enable. Every phase is timed by rising edges of the left/right frame clock, brought into the system clock domain, or by system clocks where a fixed settle time is needed.

With anti-pop enabled, power-up first clamps the outputs to ground for a hold period. It then raises a digital ramp code one step per frame until the quiescent level is reached, and only then lets audio through. Power-down with anti-pop enabled stops audio at once, detaches the output buffers and turns on a discharge sink for a minimum time. A power-up request that arrives during that time waits until the time is up. Without anti-pop, power-up is a fixed count of system clocks and power-down is immediate.

Top module: `dac_pwr_seq`

## Requirements
- R1: After `arst_n` is asserted, `status` is OFF (code 0) and `vq_en`, `audio_en`, `sink_en` and `ramp_code` are all zero. While `dac_rst_n` is low, the block is only ever in OFF or DISCHARGE. Status codes: OFF=0, WAIT=1, CLAMP=2, RAMP=3, RUN=4, DISCHARGE=5.
- R2: In pin-strap mode (`ctrl_mode`=0), after `dac_rst_n` rises the block reports WAIT with `vq_en` low. It starts power-up only after WAIT_BASE frame-clock rising edges when `speed`=00, twice that when `speed`=01, and four times that when `speed` is 1x.
- R3: In register-control mode (`ctrl_mode`=1), releasing `dac_rst_n` leaves the block in OFF. Power-up starts within two clocks of `pdn` falling, and only after `pdn` has been seen high since reset. No frame wait comes first.
- R4: With `pop_en`=0, power-up raises `vq_en`, reports WAIT, and enters RUN after FIXED_CLKS system clocks. At that point `ramp_code` equals RAMP_STEPS.
- R5: With `pop_en`=1, power-up enters CLAMP with `clamp_gnd` high and `vq_en` high. It stays there for HOLD_FRAMES frame edges.
- R6: In RAMP, `ramp_code` starts at 0 and rises by one per frame edge. The block enters RUN on the edge where the code reaches RAMP_STEPS, and the code then holds there. `audio_en` is high only in RUN.
- R7: With `pop_en`=1, a power-down request from any powered phase puts the block in DISCHARGE on the next clock, with `audio_en` and `buf_conn` low and `sink_en` high. A request is `dac_rst_n` low, or `pdn` high in register mode.
- R8: With `pop_en`=0, a power-down request goes straight to OFF with `sink_en` low.
- R9: DISCHARGE lasts exactly DISCH_CLKS system clocks. A power-up request made during it is held, then taken on leaving DISCHARGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous chip reset, active low |
| lrck | input | 1 | Left/right frame clock, asynchronous |
| dac_rst_n | input | 1 | DAC reset pin, active low, synchronous to clk |
| pdn | input | 1 | Power-down control bit (register mode) |
| ctrl_mode | input | 1 | 0 = pin-strap, 1 = register control |
| speed | input | 2 | 00 single, 01 double, 1x quad |
| pop_en | input | 1 | Anti-pop sequence enable |
| vq_en | output | 1 | Quiescent reference enable |
| clamp_gnd | output | 1 | Clamp outputs to ground |
| ramp_code | output | RW | Output level ramp code |
| audio_en | output | 1 | Audio output enable |
| buf_conn | output | 1 | Output buffers connected |
| sink_en | output | 1 | Discharge current sink enable |
| status | output | 3 | Current phase code |

## Verification
The pin-strap start-up is tried with each speed code, with and without anti-pop. The WAIT boundary is sampled one frame before and one frame after the expected edge count, so a wrong speed multiplier or an off-by-one edge count shows up. Anti-pop runs are sampled at the last CLAMP frame, inside the ramp, at the final step and after it, which separates a bad hold length, a ramp that misses steps, an early audio enable and a lost saturation. Register-mode runs check that `pdn` low alone never starts power-up. They also drop `pdn` part-way through a discharge, which tells apart a sequencer that cuts the discharge short, one that loses the held request, and one that honours it on time.

// File: rtl/dac_pwr_seq_pkg.sv
package dac_pwr_seq_pkg;

  typedef enum logic [2:0] {
    PH_OFF    = 3'd0,
    PH_WAIT   = 3'd1,
    PH_CLAMP  = 3'd2,
    PH_RAMP   = 3'd3,
    PH_RUN    = 3'd4,
    PH_DISCH  = 3'd5,
    PH_SETTLE = 3'd6
  } phase_e;

  // frame edges to wait in pin-strap mode for a speed code
  function automatic int unsigned wait_frames(input int unsigned base, input logic [1:0] spd);
    case (spd)
      2'b00:   return base;
      2'b01:   return base * 2;
      default: return base * 4;
    endcase
  endfunction

  // externally visible phase code; fixed settle reports as WAIT
  function automatic logic [2:0] status_code(input phase_e p);
    if (p == PH_SETTLE) return 3'(PH_WAIT);
    return 3'(p);
  endfunction

  function automatic logic is_powered(input phase_e p);
    return (p == PH_CLAMP) || (p == PH_RAMP) || (p == PH_RUN) || (p == PH_SETTLE);
  endfunction

endpackage

// File: rtl/dac_pwr_seq_sync.sv
module dac_pwr_seq_sync (
  input  logic clk,
  input  logic arst_n,
  input  logic lrck,
  output logic frm_tick
);
  logic s1, s2, prev;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1   <= lrck;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign frm_tick = s2 & ~prev;

  // R2: a frame edge is a single-cycle event
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!arst_n)
    frm_tick |=> !frm_tick);

endmodule

// File: rtl/dac_pwr_seq_fsm.sv
module dac_pwr_seq_fsm
  import dac_pwr_seq_pkg::*;
#(
  parameter int unsigned WAIT_BASE   = 512,
  parameter int unsigned HOLD_FRAMES = 1000,
  parameter int unsigned RAMP_STEPS  = 10000,
  parameter int unsigned FIXED_CLKS  = 12500,
  parameter int unsigned DISCH_CLKS  = 5000,
  parameter int unsigned RW          = 14
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          dac_rst_n,
  input  logic          pdn,
  input  logic          ctrl_mode,
  input  logic [1:0]    speed,
  input  logic          pop_en,
  input  logic          frm_tick,
  output phase_e        phase,
  output logic [RW-1:0] ramp_cnt
);
  localparam int unsigned MAX_A = (4 * WAIT_BASE > HOLD_FRAMES) ? 4 * WAIT_BASE : HOLD_FRAMES;
  localparam int unsigned MAX_B = (FIXED_CLKS > DISCH_CLKS) ? FIXED_CLKS : DISCH_CLKS;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW    = $clog2(MAX_C + 1);

  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_FRAMES - 1);
  localparam logic [CW-1:0] FIXED_LAST = CW'(FIXED_CLKS - 1);
  localparam logic [CW-1:0] DISCH_LAST = CW'(DISCH_CLKS - 1);
  localparam logic [RW-1:0] RAMP_TOP   = RW'(RAMP_STEPS);
  localparam logic [RW-1:0] RAMP_LAST  = RW'(RAMP_STEPS - 1);

  phase_e        nxt;
  logic [CW-1:0] ph_cnt;
  logic [CW-1:0] wait_last;
  logic          armed;
  logic          pwr_dn;     // power-down request
  logic          up_start;   // register-mode power-up taken from OFF
  phase_e        up_phase;   // first powered phase

  assign pwr_dn   = !dac_rst_n || (ctrl_mode && pdn);
  assign up_phase = pop_en ? PH_CLAMP : PH_SETTLE;
  assign up_start = (phase == PH_OFF) && ctrl_mode && (nxt != PH_OFF);

  always_comb wait_last = CW'(wait_frames(WAIT_BASE, speed) - 1);

  always_comb begin
    nxt = phase;
    case (phase)
      PH_OFF: begin
        if (dac_rst_n) begin
          if (!ctrl_mode)          nxt = PH_WAIT;
          else if (armed && !pdn)  nxt = up_phase;
        end
      end
      PH_WAIT: begin
        if (pwr_dn)                                 nxt = PH_OFF;
        else if (frm_tick && ph_cnt == wait_last)   nxt = up_phase;
      end
      PH_CLAMP: begin
        if (pwr_dn)                                 nxt = pop_en ? PH_DISCH : PH_OFF;
        else if (frm_tick && ph_cnt == HOLD_LAST)   nxt = PH_RAMP;
      end
      PH_RAMP: begin
        if (pwr_dn)                                 nxt = pop_en ? PH_DISCH : PH_OFF;
        else if (frm_tick && ramp_cnt == RAMP_LAST) nxt = PH_RUN;
      end
      PH_SETTLE: begin
        if (pwr_dn)                                 nxt = pop_en ? PH_DISCH : PH_OFF;
        else if (ph_cnt == FIXED_LAST)              nxt = PH_RUN;
      end
      PH_RUN: begin
        if (pwr_dn)                                 nxt = pop_en ? PH_DISCH : PH_OFF;
      end
      PH_DISCH: begin
        if (ph_cnt == DISCH_LAST)                   nxt = PH_OFF;
      end
      default: nxt = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase    <= PH_OFF;
      ph_cnt   <= '0;
      ramp_cnt <= '0;
      armed    <= 1'b0;
    end else begin
      phase <= nxt;

      if (nxt != phase) ph_cnt <= '0;
      else begin
        case (phase)
          PH_WAIT, PH_CLAMP:   if (frm_tick) ph_cnt <= ph_cnt + 1'b1;
          PH_SETTLE, PH_DISCH: ph_cnt <= ph_cnt + 1'b1;
          default:             ph_cnt <= '0;
        endcase
      end

      if (nxt == PH_RUN)                                        ramp_cnt <= RAMP_TOP;
      else if (phase == PH_RAMP && nxt == PH_RAMP && frm_tick)  ramp_cnt <= ramp_cnt + 1'b1;
      else if (nxt != PH_RAMP)                                  ramp_cnt <= '0;

      if (!dac_rst_n)    armed <= 1'b0;
      else if (pdn)      armed <= 1'b1;
      else if (up_start) armed <= 1'b0;
    end
  end

  // R1: reset pin low keeps the stage unpowered
  a_r1_rst_unpowered: assert property (@(posedge clk) disable iff (!arst_n)
    !dac_rst_n |=> (phase == PH_OFF || phase == PH_DISCH));

  // R3: register mode never leaves OFF without a seen high-then-low pdn
  a_r3_no_spurious_up: assert property (@(posedge clk) disable iff (!arst_n)
    (phase == PH_OFF && ctrl_mode && !armed) |=> phase == PH_OFF);

  // R5: clamp held until a frame edge ends the hold
  a_r5_clamp_hold: assert property (@(posedge clk) disable iff (!arst_n)
    (phase == PH_CLAMP && !frm_tick && !pwr_dn) |=> phase == PH_CLAMP);

  // R6: ramp advances one step per frame edge
  a_r6_ramp_step: assert property (@(posedge clk) disable iff (!arst_n)
    (phase == PH_RAMP && frm_tick && !pwr_dn) |=> ramp_cnt == $past(ramp_cnt) + 1'b1);

  // R7: power-down from a powered phase acts on the next clock
  a_r7_prompt_down: assert property (@(posedge clk) disable iff (!arst_n)
    (is_powered(phase) && pwr_dn) |=> (phase == PH_DISCH || phase == PH_OFF));

  // R9: discharge is not cut short
  a_r9_disch_min: assert property (@(posedge clk) disable iff (!arst_n)
    (phase == PH_DISCH && ph_cnt != DISCH_LAST) |=> phase == PH_DISCH);

endmodule

// File: rtl/dac_pwr_seq_out.sv
module dac_pwr_seq_out
  import dac_pwr_seq_pkg::*;
#(
  parameter int unsigned RW         = 14,
  parameter int unsigned RAMP_STEPS = 10000
) (
  input  logic          clk,
  input  logic          arst_n,
  input  phase_e        phase,
  input  logic [RW-1:0] ramp_cnt,
  output logic          vq_en,
  output logic          clamp_gnd,
  output logic [RW-1:0] ramp_code,
  output logic          audio_en,
  output logic          buf_conn,
  output logic          sink_en,
  output logic [2:0]    status
);
  always_comb begin
    vq_en     = is_powered(phase);
    clamp_gnd = (phase == PH_CLAMP);
    buf_conn  = (phase == PH_RAMP) || (phase == PH_RUN) || (phase == PH_SETTLE);
    audio_en  = (phase == PH_RUN);
    sink_en   = (phase == PH_DISCH);
    ramp_code = ramp_cnt;
    status    = status_code(phase);
  end

  // R6: audio only ever flows at the full quiescent code
  a_r6_audio_full: assert property (@(posedge clk) disable iff (!arst_n)
    audio_en |-> ramp_code == RW'(RAMP_STEPS));

endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
  import dac_pwr_seq_pkg::*;
#(
  parameter int unsigned WAIT_BASE   = 512,
  parameter int unsigned HOLD_FRAMES = 1000,
  parameter int unsigned RAMP_STEPS  = 10000,
  parameter int unsigned FIXED_CLKS  = 12500,
  parameter int unsigned DISCH_CLKS  = 5000,
  parameter int unsigned RW          = 14
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          lrck,
  input  logic          dac_rst_n,
  input  logic          pdn,
  input  logic          ctrl_mode,
  input  logic [1:0]    speed,
  input  logic          pop_en,
  output logic          vq_en,
  output logic          clamp_gnd,
  output logic [RW-1:0] ramp_code,
  output logic          audio_en,
  output logic          buf_conn,
  output logic          sink_en,
  output logic [2:0]    status
);
  logic          frm_tick;
  phase_e        phase;
  logic [RW-1:0] ramp_cnt;

  dac_pwr_seq_sync u_sync (
    .clk      (clk),
    .arst_n   (arst_n),
    .lrck     (lrck),
    .frm_tick (frm_tick)
  );

  dac_pwr_seq_fsm #(
    .WAIT_BASE   (WAIT_BASE),
    .HOLD_FRAMES (HOLD_FRAMES),
    .RAMP_STEPS  (RAMP_STEPS),
    .FIXED_CLKS  (FIXED_CLKS),
    .DISCH_CLKS  (DISCH_CLKS),
    .RW          (RW)
  ) u_fsm (
    .clk       (clk),
    .arst_n    (arst_n),
    .dac_rst_n (dac_rst_n),
    .pdn       (pdn),
    .ctrl_mode (ctrl_mode),
    .speed     (speed),
    .pop_en    (pop_en),
    .frm_tick  (frm_tick),
    .phase     (phase),
    .ramp_cnt  (ramp_cnt)
  );

  dac_pwr_seq_out #(
    .RW         (RW),
    .RAMP_STEPS (RAMP_STEPS)
  ) u_out (
    .clk       (clk),
    .arst_n    (arst_n),
    .phase     (phase),
    .ramp_cnt  (ramp_cnt),
    .vq_en     (vq_en),
    .clamp_gnd (clamp_gnd),
    .ramp_code (ramp_code),
    .audio_en  (audio_en),
    .buf_conn  (buf_conn),
    .sink_en   (sink_en),
    .status    (status)
  );

endmodule

// File: tb/dac_pwr_seq_tb_top.sv
module dac_pwr_seq_tb_top;
  localparam int WB = 4, HOLD = 6, RSTEPS = 10, FIXC = 30, DISC = 40, RW = 14;
  localparam int S_OFF = 0, S_WAIT = 1, S_CLAMP = 2, S_RAMP = 3, S_RUN = 4, S_DISCH = 5;

  // {speed[1:0], pop, expected wait frames[8:0]}
  localparam logic [11:0] VEC [0:3] = '{
    {2'b00, 1'b1, 9'd4},
    {2'b01, 1'b0, 9'd8},
    {2'b10, 1'b1, 9'd16},
    {2'b11, 1'b0, 9'd16}
  };

  logic clk = 1'b0, arst_n = 1'b0, lrck = 1'b0;
  logic dac_rst_n = 1'b0, pdn = 1'b0, ctrl_mode = 1'b0, pop_en = 1'b0;
  logic [1:0] speed = 2'b00;
  logic vq_en, clamp_gnd, audio_en, buf_conn, sink_en;
  logic [RW-1:0] ramp_code;
  logic [2:0] status;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;
  always begin
    repeat (4) @(negedge clk);
    lrck = ~lrck;
  end

  dac_pwr_seq #(.WAIT_BASE(WB), .HOLD_FRAMES(HOLD), .RAMP_STEPS(RSTEPS),
                .FIXED_CLKS(FIXC), .DISCH_CLKS(DISC), .RW(RW)) dut_i (
    .clk(clk), .arst_n(arst_n), .lrck(lrck), .dac_rst_n(dac_rst_n), .pdn(pdn),
    .ctrl_mode(ctrl_mode), .speed(speed), .pop_en(pop_en), .vq_en(vq_en),
    .clamp_gnd(clamp_gnd), .ramp_code(ramp_code), .audio_en(audio_en),
    .buf_conn(buf_conn), .sink_en(sink_en), .status(status));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frames(input int n);
    repeat (n) @(posedge lrck);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status after chip reset", status, S_OFF);
    chk("R1 vq_en after chip reset", vq_en, 0);
    chk("R1 audio_en after chip reset", audio_en, 0);
    chk("R1 ramp_code after chip reset", ramp_code, 0);
    arst_n = 1'b1;

    for (int v = 0; v < 4; v++) begin
      int w;
      logic p;
      w = int'(VEC[v][8:0]);
      p = VEC[v][9];
      dac_rst_n = 1'b0;
      repeat (60) @(negedge clk);
      chk("R1 status with reset pin low", status, S_OFF);
      chk("R1 sink_en with reset pin low", sink_en, 0);
      ctrl_mode = 1'b0; speed = VEC[v][11:10]; pop_en = p;
      @(negedge lrck);
      dac_rst_n = 1'b1;
      frames(w - 1);
      chk("R2 still waiting one frame early", status, S_WAIT);
      chk("R2 vq_en low during wait", vq_en, 0);
      frames(1);
      chk("R2 power-up after speed wait", vq_en, 1);
      if (p) begin
        chk("R5 clamp phase entered", status, S_CLAMP);
        chk("R5 clamp_gnd high", clamp_gnd, 1);
        frames(HOLD - 1);
        chk("R5 clamp held to last frame", status, S_CLAMP);
        frames(1);
        chk("R6 ramp phase entered", status, S_RAMP);
        chk("R6 ramp starts at zero", ramp_code, 0);
        frames(4);
        chk("R6 ramp mid value", ramp_code, 4);
        frames(5);
        chk("R6 ramp one below top", ramp_code, RSTEPS - 1);
        chk("R6 audio off before top", audio_en, 0);
        frames(1);
        chk("R6 run at top", status, S_RUN);
        chk("R6 audio on at top", audio_en, 1);
        frames(2);
        chk("R6 ramp saturates", ramp_code, RSTEPS);
      end else begin
        chk("R4 fixed settle reported as wait", status, S_WAIT);
        chk("R4 audio off during settle", audio_en, 0);
        repeat (20) @(negedge clk);
        chk("R4 still settling", audio_en, 0);
        repeat (15) @(negedge clk);
        chk("R4 run after fixed time", status, S_RUN);
        chk("R4 ramp_code full", ramp_code, RSTEPS);
      end
      dac_rst_n = 1'b0;
      @(negedge clk);
      chk(p ? "R7 reset pin starts discharge" : "R8 reset pin goes off", status, p ? S_DISCH : S_OFF);
      chk("R7 audio stops at once", audio_en, 0);
      chk(p ? "R7 sink on" : "R8 sink stays off", sink_en, int'(p));
    end

    // register-control mode
    dac_rst_n = 1'b0;
    repeat (60) @(negedge clk);
    ctrl_mode = 1'b1; pdn = 1'b0; pop_en = 1'b1; speed = 2'b00;
    dac_rst_n = 1'b1;
    frames(40);
    chk("R3 no power-up without pdn cycle", status, S_OFF);
    pdn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 pdn high holds off", status, S_OFF);
    pdn = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 immediate power-up on pdn fall", status, S_CLAMP);
    frames(HOLD + RSTEPS + 2);
    chk("R3 reaches run", status, S_RUN);
    pdn = 1'b1;
    @(negedge clk);
    chk("R7 pdn starts discharge", status, S_DISCH);
    chk("R7 buffers detached", buf_conn, 0);
    chk("R7 sink enabled", sink_en, 1);
    repeat (19) @(negedge clk);
    pdn = 1'b0;
    repeat (19) @(negedge clk);
    chk("R9 discharge not cut short", status, S_DISCH);
    repeat (5) @(negedge clk);
    chk("R9 held request taken after discharge", status, S_CLAMP);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule